// File: doc/BRIEF.md
# Storage Channel Interrupt Status Unit

This unit collects two interrupt sources of a storage channel, a channel completion event and a DMA bus error, in a pair of pending flags. Software sees the flags through a word-addressed register port: a pending view that clears flags by writing ones, and an enable mask that is changed through separate set and clear words. A single level interrupt output is high while any pending flag has its enable bit set.

The unit also watches reads of the attached device's task-file status byte, which sits 0x110 bytes above the pending word. The unit returns the device's status byte on that read. When the BUSY bit of that byte is clear, the read acknowledges both pending flags. Software can therefore acknowledge the interrupt just by polling status once the device has gone idle.

Every access is sorted into one of five access kinds: NONE (unmapped or no access), PEND, ESET, ECLR and STAT. Each kind selects read data and a register update. There is no sequential state machine. The only state is the two pending flags and the two enable bits.

Top module: `chan_irq_unit`

## Requirements
- R1: After reset both pending flags and both enable bits are 0, and `irq_o` is 0.
- R2: A one-cycle pulse on `ev_chan_i` sets pending bit 0, and a pulse on `ev_dmaerr_i` sets pending bit 1. Reading byte address 0x00C returns the pending flags in bits 1:0 from the cycle after the pulse.
- R3: A write to 0x00C clears each pending bit whose write-data bit is 1. Bits written as 0 are left as they are.
- R4: When a source event and a clear of the same pending bit fall in the same cycle, the event wins and the bit stays set.
- R5: A write to 0x014 sets each enable bit whose write-data bit (1:0) is 1. Reading 0x014 returns the enable mask in bits 1:0.
- R6: A write to 0x01C clears each enable bit whose write-data bit is 1. Reading 0x01C also returns the enable mask.
- R7: `irq_o` is 1 exactly when some pending bit and its enable bit are both 1, with no extra cycle after the register update.
- R8: A read of 0x11C returns `dev_status_i` in bits 7:0. If bit 7 (BUSY) of that byte is 0, both pending flags are cleared at that clock edge. If it is 1, the flags are unchanged.
- R9: A source event in the same cycle as an acknowledging status read keeps its pending bit set.
- R10: Reads of any other address return 0. Writes to other addresses and to 0x11C change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_chan_i | input | 1 | Channel interrupt event pulse |
| ev_dmaerr_i | input | 1 | DMA bus error event pulse |
| acc_en_i | input | 1 | Register access in this cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W (12) | Byte address of the access |
| acc_wdata_i | input | DATA_W (32) | Write data |
| dev_status_i | input | 8 | Device task-file status byte |
| acc_rdata_o | output | DATA_W (32) | Read data, valid in the access cycle |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two updates can land on the same pending flag in one cycle: a source event, and a clear from either the write-one-clear word or an acknowledging status read. The bench provokes both cases. It drives an event pulse in the very cycle of a clear write to 0x00C, and again in the cycle of a status read with BUSY low. The queued expected read-back then requires the flag that had the event to stay set, while the other flag is cleared.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
    localparam int NSRC       = 2;
    localparam int WORD_BYTES = 4;
    localparam int PEND_WORD  = 3;
    localparam int ESET_WORD  = 5;
    localparam int ECLR_WORD  = 7;
    localparam int STAT_GAP   = 'h110;
    localparam int PEND_BYTE  = PEND_WORD * WORD_BYTES;
    localparam int ESET_BYTE  = ESET_WORD * WORD_BYTES;
    localparam int ECLR_BYTE  = ECLR_WORD * WORD_BYTES;
    localparam int STAT_BYTE  = PEND_BYTE + STAT_GAP;
    localparam int BUSY_BIT   = 7;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PEND,
        ACC_ESET,
        ACC_ECLR,
        ACC_STAT
    } acc_kind_e;
endpackage

// File: rtl/chan_irq_decode.sv
module chan_irq_decode
    import chan_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              acc_en_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    output acc_kind_e         kind_o
);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_BYTE);
    localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(ESET_BYTE);
    localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(ECLR_BYTE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_BYTE);

    always_comb begin
        kind_o = ACC_NONE;
        if (acc_en_i) begin
            if (acc_addr_i == A_PEND)      kind_o = ACC_PEND;
            else if (acc_addr_i == A_ESET) kind_o = ACC_ESET;
            else if (acc_addr_i == A_ECLR) kind_o = ACC_ECLR;
            else if (acc_addr_i == A_STAT) kind_o = ACC_STAT;
        end
    end
endmodule

// File: rtl/chan_irq_pend_bit.sv
module chan_irq_pend_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (ev_i)   q_o <= 1'b1;
        else if (clr_i)  q_o <= 1'b0;
    end

    // R4
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i |=> q_o);

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !ev_i) |=> !q_o);
endmodule

// File: rtl/chan_irq_unit.sv
module chan_irq_unit
    import chan_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_chan_i,
    input  logic              ev_dmaerr_i,
    input  logic              acc_en_i,
    input  logic              acc_wr_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] acc_wdata_i,
    input  logic [7:0]        dev_status_i,
    output logic [DATA_W-1:0] acc_rdata_o,
    output logic              irq_o
);
    acc_kind_e       kind;
    logic [NSRC-1:0] ev_vec;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] pend_clr;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] wmask;
    logic            ack;
    logic            set_stb;
    logic            clr_stb;
    logic            unused_wdata;

    assign ev_vec       = {ev_dmaerr_i, ev_chan_i};
    assign wmask        = acc_wdata_i[NSRC-1:0];
    assign unused_wdata = ^acc_wdata_i[DATA_W-1:NSRC];

    chan_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .acc_en_i  (acc_en_i),
        .acc_addr_i(acc_addr_i),
        .kind_o    (kind)
    );

    always_comb begin
        acc_rdata_o = '0;
        pend_clr    = '0;
        ack         = 1'b0;
        set_stb     = 1'b0;
        clr_stb     = 1'b0;
        unique case (kind)
            ACC_NONE: ;
            ACC_PEND: begin
                acc_rdata_o[NSRC-1:0] = pend;
                if (acc_wr_i) pend_clr = wmask;
            end
            ACC_ESET: begin
                acc_rdata_o[NSRC-1:0] = en_q;
                set_stb = acc_wr_i;
            end
            ACC_ECLR: begin
                acc_rdata_o[NSRC-1:0] = en_q;
                clr_stb = acc_wr_i;
            end
            ACC_STAT: begin
                acc_rdata_o[7:0] = dev_status_i;
                if (!acc_wr_i && !dev_status_i[BUSY_BIT]) begin
                    ack      = 1'b1;
                    pend_clr = '1;
                end
            end
            default: ;
        endcase
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        chan_irq_pend_bit u_pend (
            .clk  (clk),
            .rst_n(rst_n),
            .ev_i (ev_vec[i]),
            .clr_i(pend_clr[i]),
            .q_o  (pend[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (set_stb) en_q <= en_q | wmask;
        else if (clr_stb) en_q <= en_q & ~wmask;
    end

    assign irq_o = |(pend & en_q);

    // R5
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((en_q & $past(wmask)) == $past(wmask)));

    // R6
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((en_q & $past(wmask)) == '0));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ev_vec == '0) |=> (pend == '0));
endmodule

// File: tb/chan_irq_unit_tb.sv
module chan_irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_c = 1'b0, ev_d = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [7:0]  dev_st = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    chan_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ev_chan_i(ev_c), .ev_dmaerr_i(ev_d),
        .acc_en_i(acc_en), .acc_wr_i(acc_wr), .acc_addr_i(acc_addr),
        .acc_wdata_i(acc_wdata), .dev_status_i(dev_st),
        .acc_rdata_o(rdata), .irq_o(irq)
    );

    localparam logic [11:0] PEND = 12'h00C, ESET = 12'h014,
                            ECLR = 12'h01C, STAT = 12'h11C;

    task automatic cyc(input logic ec, input logic ed, input logic en,
                       input logic wr, input logic [11:0] a,
                       input logic [31:0] d, input logic [7:0] st);
        @(negedge clk);
        ev_c = ec; ev_d = ed; acc_en = en; acc_wr = wr;
        acc_addr = a; acc_wdata = d; dev_st = st;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, '0, '0, '0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(0, 0, 1, 1, a, d, '0);
    endtask

    task automatic rd(input logic [11:0] a, input logic [7:0] st,
                      input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cyc(0, 0, 1, 0, a, '0, st);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        idle();
        #5;
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp);
        end
    endtask

    // monitor: pops expected read data for every read access
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (acc_en && !acc_wr) begin
                logic [31:0] e;
                string t;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard read with no expectation actual %h expected none", rdata);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rdata !== e) begin
                        errors++;
                        $display("FAIL %s rdata actual %h expected %h", t, rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(PEND, 0, 32'h0, "R1");
        rd(ESET, 0, 32'h0, "R1");
        chk_irq(0, "R1");
        // R2 sources set pending bits
        cyc(1, 0, 0, 0, '0, '0, '0);
        rd(PEND, 0, 32'h1, "R2");
        chk_irq(0, "R7 masked");
        cyc(0, 1, 0, 0, '0, '0, '0);
        rd(PEND, 0, 32'h3, "R2");
        // R3 write-one-clear per bit
        wr(PEND, 32'h1);
        rd(PEND, 0, 32'h2, "R3");
        wr(PEND, 32'h2);
        rd(PEND, 0, 32'h0, "R3");
        // R5 / R6 enable set and read views
        wr(ESET, 32'h3);
        rd(ESET, 0, 32'h3, "R5");
        rd(ECLR, 0, 32'h3, "R6");
        chk_irq(0, "R7 no pending");
        cyc(1, 0, 0, 0, '0, '0, '0);
        chk_irq(1, "R7");
        wr(ECLR, 32'h1);
        rd(ESET, 0, 32'h2, "R6");
        chk_irq(0, "R7 disabled source");
        cyc(0, 1, 0, 0, '0, '0, '0);
        chk_irq(1, "R7");
        // R4 event beats clear in same cycle
        cyc(1, 0, 1, 1, PEND, 32'h3, '0);
        rd(PEND, 0, 32'h1, "R4");
        // R8 status read with BUSY set: no acknowledge
        rd(STAT, 8'h80, 32'h80, "R8 busy");
        rd(PEND, 0, 32'h1, "R8 busy");
        // R8 status read with BUSY clear: acknowledge
        rd(STAT, 8'h50, 32'h50, "R8");
        rd(PEND, 0, 32'h0, "R8");
        chk_irq(0, "R8");
        // R9 event during acknowledging read
        cyc(0, 1, 0, 0, '0, '0, '0);
        exp_q.push_back(32'h0); tag_q.push_back("R9");
        cyc(1, 0, 1, 0, STAT, '0, 8'h00);
        rd(PEND, 0, 32'h1, "R9");
        // R10 unmapped and read-only addresses
        rd(12'h040, 0, 32'h0, "R10");
        wr(STAT, 32'h3);
        wr(12'h010, 32'h3);
        wr(12'h018, 32'h3);
        rd(ESET, 0, 32'h2, "R10");
        rd(PEND, 0, 32'h1, "R10");
        idle();
        idle();
        #5;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover actual %0d expected 0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule